// File: doc/BRIEF.md
# Four-Port Set/Clear GPIO Controller

This block is a memory-mapped general-purpose I/O controller. It serves three bidirectional ports of 8, 24 and 13 pins, a fourth bidirectional port of 6 pins, a group of 24 output-only pins and a group of 22 input-only pins. Software changes output levels, pin directions and one port-function select word through paired write-one-to-set and write-one-to-clear addresses, so a write touches only the bits written as 1 and never needs a read-modify-write. State addresses read back the latched output and direction values and the synchronized pad levels.

The fourth bidirectional port has no registers of its own. Its output level bits sit at positions 25 to 30 of the word that also drives the 24 output-only pins. Its direction bits sit at the same positions in the third port's direction word. On the input side its pins are read at scattered positions of the word that carries the input-only group. Register access uses a plain synchronous bus: the address, the write data and the write strobe are sampled on the rising clock edge, and read data is a combinational function of the address.

Top module: `gpio_quad_port`

## Requirements
- R1: After reset every output level, every output enable and the select word are 0. All state reads return 0 while the pads are held low.
- R2: A write to an output-set or direction-set address forces to 1 the bits written as 1. All other bits keep their value.
- R3: A write to an output-clear or direction-clear address forces to 0 the bits written as 1. All other bits keep their value.
- R4: A direction bit of 1 drives the pin's output enable high (output). A direction bit of 0 makes the pin an input. Byte offsets for port A (8 pins): input 0x40, out set 0x44, out clear 0x48, out state 0x4C, dir set 0x50, dir clear 0x54, dir state 0x58. Port B (24 pins) uses the same layout at 0x60 to 0x78. Port C (13 pins): dir set/clear/state 0x10/0x14/0x18, input 0x1C, out set/clear 0x20/0x24.
- R5: The shared high word has set, clear and state at 0x04, 0x08 and 0x0C. Its bits 0 to 23 drive the output-only pins. Bits 25 to 30 drive port D pin n at bit n+25. Port D output enables come from bits 25 to 30 of port C's direction word. Bit 24 and bit 31 of both words always read 0.
- R6: The input word at 0x00 carries port D pins 0 to 4 at bits 10 to 14 and pin 5 at bit 24. Input-only pin k fills the remaining positions in rising order: bits 0 to 9, then 15 to 23, then 25 to 27. Bits 28 to 31 read 0.
- R7: A pad level change appears in the input state reads after exactly two rising clock edges.
- R8: The output state addresses return the latched output values, not the pad levels.
- R9: Reads of set, clear and unmapped addresses (including offsets not a multiple of 4) return 0.
- R10: Writes to state addresses and to unmapped addresses change no output and no register.
- R11: The select word (13 bits) has set, clear and state at 0x28, 0x2C and 0x30. It drives the `fn_sel` output.
- R12: Pin n of ports A, B and C uses bit n. Write bits above a port's width are ignored, and those bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data for bus_addr |
| pa_in | input | 8 | Port A pad levels |
| pa_out | output | 8 | Port A output levels |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 24 | Port B pad levels |
| pb_out | output | 24 | Port B output levels |
| pb_oe | output | 24 | Port B output enables |
| pc_in | input | 13 | Port C pad levels |
| pc_out | output | 13 | Port C output levels |
| pc_oe | output | 13 | Port C output enables |
| pd_in | input | 6 | Port D pad levels |
| pd_out | output | 6 | Port D output levels |
| pd_oe | output | 6 | Port D output enables |
| gpi_pad | input | 22 | Input-only pin levels |
| gpo_pad | output | 24 | Output-only pin levels |
| fn_sel | output | 13 | Port function select word |

## Verification
The hardest case to reach is the interleaving of the shared words. A set or clear aimed at the output-only pins, or at port C's direction, must leave port D's bits alone, and the reverse must also hold. On the input side, port D pins and input-only pins must land at the right scattered positions at the same time. Directed writes of all-ones and sparse masks to the shared addresses cover these words. Random pad patterns, applied after the synchronizer has settled, are then checked bit by bit against a bench model of the input word layout. The two-edge input delay is checked directly by sampling between the two edges.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 8;
  localparam int unsigned PA_W = 8;
  localparam int unsigned PB_W = 24;
  localparam int unsigned PC_W = 13;
  localparam int unsigned PD_W = 6;
  localparam int unsigned GPO_W = 24;
  localparam int unsigned GPI_W = 22;
  localparam int unsigned SEL_W = 13;
  localparam int unsigned PD_BASE = 25;     // port D bit 0 in shared out/dir words
  localparam int unsigned PD_IN_LO = 10;    // port D pins 0..4 in input word
  localparam int unsigned PD_IN_TOP = 24;   // port D last pin in input word
  localparam int unsigned HI_IN_SPAN = GPI_W + PD_W;
  localparam int unsigned PAD_W = PA_W + PB_W + PC_W + PD_W + GPI_W;

  localparam logic [DW-1:0] PD_FIELD = ((DW'(1) << PD_W) - 1) << PD_BASE;
  localparam logic [DW-1:0] HI_OUT_MASK = ((DW'(1) << GPO_W) - 1) | PD_FIELD;
  localparam logic [DW-1:0] PC_DIR_MASK = ((DW'(1) << PC_W) - 1) | PD_FIELD;

  localparam logic [AW-1:0] A_HI_IN     = 8'h00;
  localparam logic [AW-1:0] A_HI_SET    = 8'h04;
  localparam logic [AW-1:0] A_HI_CLR    = 8'h08;
  localparam logic [AW-1:0] A_HI_ST     = 8'h0C;
  localparam logic [AW-1:0] A_PC_DSET   = 8'h10;
  localparam logic [AW-1:0] A_PC_DCLR   = 8'h14;
  localparam logic [AW-1:0] A_PC_DST    = 8'h18;
  localparam logic [AW-1:0] A_PC_IN     = 8'h1C;
  localparam logic [AW-1:0] A_PC_OSET   = 8'h20;
  localparam logic [AW-1:0] A_PC_OCLR   = 8'h24;
  localparam logic [AW-1:0] A_SEL_SET   = 8'h28;
  localparam logic [AW-1:0] A_SEL_CLR   = 8'h2C;
  localparam logic [AW-1:0] A_SEL_ST    = 8'h30;
  localparam logic [AW-1:0] A_PA_IN     = 8'h40;
  localparam logic [AW-1:0] A_PA_OSET   = 8'h44;
  localparam logic [AW-1:0] A_PA_OCLR   = 8'h48;
  localparam logic [AW-1:0] A_PA_OST    = 8'h4C;
  localparam logic [AW-1:0] A_PA_DSET   = 8'h50;
  localparam logic [AW-1:0] A_PA_DCLR   = 8'h54;
  localparam logic [AW-1:0] A_PA_DST    = 8'h58;
  localparam logic [AW-1:0] A_PB_IN     = 8'h60;
  localparam logic [AW-1:0] A_PB_OSET   = 8'h64;
  localparam logic [AW-1:0] A_PB_OCLR   = 8'h68;
  localparam logic [AW-1:0] A_PB_OST    = 8'h6C;
  localparam logic [AW-1:0] A_PB_DSET   = 8'h70;
  localparam logic [AW-1:0] A_PB_DCLR   = 8'h74;
  localparam logic [AW-1:0] A_PB_DST    = 8'h78;

  // Interleave port D pins and input-only pins into the shared input word.
  function automatic logic [DW-1:0] hi_in_word(input logic [PD_W-1:0] bi,
                                               input logic [GPI_W-1:0] ded);
    logic [DW-1:0] w;
    int k;
    w = '0;
    k = 0;
    for (int j = 0; j < int'(HI_IN_SPAN); j++) begin
      if (j >= int'(PD_IN_LO) && j < int'(PD_IN_LO + PD_W - 1)) begin
        w[j] = bi[j - int'(PD_IN_LO)];
      end else if (j == int'(PD_IN_TOP)) begin
        w[j] = bi[PD_W-1];
      end else begin
        w[j] = ded[k];
        k++;
      end
    end
    return w;
  endfunction
endpackage

// File: rtl/gpio_sc_reg.sv
module gpio_sc_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;
  logic         q_en;

  always_comb begin
    q_en  = set_en | clr_en;
    q_nxt = q;
    if (set_en)      q_nxt = (q | wdata) & MASK;
    else if (clr_en) q_nxt = q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_nxt;
    if (s == 0) begin : g_first
      assign stg_nxt = d;
    end else begin : g_rest
      assign stg_nxt = stg[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg_nxt;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_quad_port.sv
module gpio_quad_port
  import gpio_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             bus_we,
  output logic [DW-1:0]    bus_rdata,
  input  logic [PA_W-1:0]  pa_in,
  output logic [PA_W-1:0]  pa_out,
  output logic [PA_W-1:0]  pa_oe,
  input  logic [PB_W-1:0]  pb_in,
  output logic [PB_W-1:0]  pb_out,
  output logic [PB_W-1:0]  pb_oe,
  input  logic [PC_W-1:0]  pc_in,
  output logic [PC_W-1:0]  pc_out,
  output logic [PC_W-1:0]  pc_oe,
  input  logic [PD_W-1:0]  pd_in,
  output logic [PD_W-1:0]  pd_out,
  output logic [PD_W-1:0]  pd_oe,
  input  logic [GPI_W-1:0] gpi_pad,
  output logic [GPO_W-1:0] gpo_pad,
  output logic [SEL_W-1:0] fn_sel
);
  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  // Write strobes
  function automatic logic hit(input logic [AW-1:0] a);
    return bus_we && (bus_addr == a);
  endfunction

  logic [DW-1:0] hi_out_q, pc_dir_q, hi_in_w;

  gpio_sc_reg #(.W(PA_W)) u_pa_out (.clk, .rst_n(rst_core_n),
    .set_en(hit(A_PA_OSET)), .clr_en(hit(A_PA_OCLR)), .wdata(bus_wdata[PA_W-1:0]), .q(pa_out));
  gpio_sc_reg #(.W(PA_W)) u_pa_dir (.clk, .rst_n(rst_core_n),
    .set_en(hit(A_PA_DSET)), .clr_en(hit(A_PA_DCLR)), .wdata(bus_wdata[PA_W-1:0]), .q(pa_oe));
  gpio_sc_reg #(.W(PB_W)) u_pb_out (.clk, .rst_n(rst_core_n),
    .set_en(hit(A_PB_OSET)), .clr_en(hit(A_PB_OCLR)), .wdata(bus_wdata[PB_W-1:0]), .q(pb_out));
  gpio_sc_reg #(.W(PB_W)) u_pb_dir (.clk, .rst_n(rst_core_n),
    .set_en(hit(A_PB_DSET)), .clr_en(hit(A_PB_DCLR)), .wdata(bus_wdata[PB_W-1:0]), .q(pb_oe));
  gpio_sc_reg #(.W(PC_W)) u_pc_out (.clk, .rst_n(rst_core_n),
    .set_en(hit(A_PC_OSET)), .clr_en(hit(A_PC_OCLR)), .wdata(bus_wdata[PC_W-1:0]), .q(pc_out));
  gpio_sc_reg #(.W(DW), .MASK(PC_DIR_MASK)) u_pc_dir (.clk, .rst_n(rst_core_n),
    .set_en(hit(A_PC_DSET)), .clr_en(hit(A_PC_DCLR)), .wdata(bus_wdata), .q(pc_dir_q));
  gpio_sc_reg #(.W(DW), .MASK(HI_OUT_MASK)) u_hi_out (.clk, .rst_n(rst_core_n),
    .set_en(hit(A_HI_SET)), .clr_en(hit(A_HI_CLR)), .wdata(bus_wdata), .q(hi_out_q));
  gpio_sc_reg #(.W(SEL_W)) u_sel (.clk, .rst_n(rst_core_n),
    .set_en(hit(A_SEL_SET)), .clr_en(hit(A_SEL_CLR)), .wdata(bus_wdata[SEL_W-1:0]), .q(fn_sel));

  assign pc_oe   = pc_dir_q[PC_W-1:0];
  assign pd_oe   = pc_dir_q[PD_BASE +: PD_W];
  assign pd_out  = hi_out_q[PD_BASE +: PD_W];
  assign gpo_pad = hi_out_q[GPO_W-1:0];

  // Pad input synchronization
  logic [PAD_W-1:0]  pad_raw, pad_s;
  logic [PA_W-1:0]   pa_s;
  logic [PB_W-1:0]   pb_s;
  logic [PC_W-1:0]   pc_s;
  logic [PD_W-1:0]   pd_s;
  logic [GPI_W-1:0]  gpi_s;

  assign pad_raw = {gpi_pad, pd_in, pc_in, pb_in, pa_in};
  gpio_sync #(.W(PAD_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n(rst_core_n), .d(pad_raw), .q(pad_s));
  assign {gpi_s, pd_s, pc_s, pb_s, pa_s} = pad_s;

  assign hi_in_w = hi_in_word(pd_s, gpi_s);

  // Read mux
  always_comb begin
    unique case (bus_addr)
      A_HI_IN:   bus_rdata = hi_in_w;
      A_HI_ST:   bus_rdata = hi_out_q;
      A_PC_DST:  bus_rdata = pc_dir_q;
      A_PC_IN:   bus_rdata = DW'(pc_s);
      A_SEL_ST:  bus_rdata = DW'(fn_sel);
      A_PA_IN:   bus_rdata = DW'(pa_s);
      A_PA_OST:  bus_rdata = DW'(pa_out);
      A_PA_DST:  bus_rdata = DW'(pa_oe);
      A_PB_IN:   bus_rdata = DW'(pb_s);
      A_PB_OST:  bus_rdata = DW'(pb_out);
      A_PB_DST:  bus_rdata = DW'(pb_oe);
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_quad_port_chk.sv
module gpio_quad_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        bus_we,
  input logic [31:0] bus_rdata,
  input logic [7:0]  pa_in,
  input logic [7:0]  pa_out,
  input logic [7:0]  pa_oe,
  input logic [5:0]  pd_out,
  input logic [23:0] gpo_pad
);
  logic [2:0] since_rst;
  logic       live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end
  assign live = (since_rst == 3'd7);

  // R2
  pa_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && bus_we && bus_addr == 8'h44 |=> pa_out == ($past(pa_out) | $past(bus_wdata[7:0])));
  // R3
  pa_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && bus_we && bus_addr == 8'h48 |=> pa_out == ($past(pa_out) & ~$past(bus_wdata[7:0])));
  // R4
  pa_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && bus_we && bus_addr == 8'h50 |=> pa_oe == ($past(pa_oe) | $past(bus_wdata[7:0])));
  // R5
  hi_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && bus_we && bus_addr == 8'h04 |=>
      pd_out == ($past(pd_out) | $past(bus_wdata[30:25])) &&
      gpo_pad == ($past(gpo_pad) | $past(bus_wdata[23:0])));
  // R7
  in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && bus_addr == 8'h40 |-> bus_rdata == {24'h0, $past(pa_in, 2)});
  // R9
  setclr_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h44 || bus_addr == 8'h48 || bus_addr == 8'h34) |-> bus_rdata == 32'h0);
  // R10
  state_wr_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && bus_we && bus_addr == 8'h4C |=> $stable(pa_out) && $stable(pa_oe));
endmodule

bind gpio_quad_port gpio_quad_port_chk u_chk (.*);

// File: tb/tb_gpio_quad_port.sv
module tb_gpio_quad_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  pa_in = '0, pa_out, pa_oe;
  logic [23:0] pb_in = '0, pb_out, pb_oe;
  logic [12:0] pc_in = '0, pc_out, pc_oe;
  logic [5:0]  pd_in = '0, pd_out, pd_oe;
  logic [21:0] gpi_pad = '0;
  logic [23:0] gpo_pad;
  logic [12:0] fn_sel;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model of the registers
  logic [7:0]  m_pa_out = '0, m_pa_dir = '0;
  logic [23:0] m_pb_out = '0, m_pb_dir = '0;
  logic [12:0] m_pc_out = '0, m_sel = '0;
  logic [31:0] m_pc_dir = '0, m_hi_out = '0;

  always #5 clk = ~clk;

  gpio_quad_port dut (.*);

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_in_word(input logic [5:0] d, input logic [21:0] g);
    logic [31:0] w = '0;
    int k = 0;
    for (int j = 0; j < 28; j++) begin
      if (j >= 10 && j <= 14) w[j] = d[j-10];
      else if (j == 24)       w[j] = d[5];
      else begin w[j] = g[k]; k++; end
    end
    return w;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00: return exp_in_word(pd_in, gpi_pad);
      8'h0C: return m_hi_out;
      8'h18: return m_pc_dir;
      8'h1C: return {19'h0, pc_in};
      8'h30: return {19'h0, m_sel};
      8'h40: return {24'h0, pa_in};
      8'h4C: return {24'h0, m_pa_out};
      8'h58: return {24'h0, m_pa_dir};
      8'h60: return {8'h0, pb_in};
      8'h6C: return {8'h0, m_pb_out};
      8'h78: return {8'h0, m_pb_dir};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_wr(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h04: m_hi_out = (m_hi_out | d) & 32'h7EFF_FFFF;
      8'h08: m_hi_out = m_hi_out & ~d;
      8'h10: m_pc_dir = (m_pc_dir | d) & 32'h7E00_1FFF;
      8'h14: m_pc_dir = m_pc_dir & ~d;
      8'h20: m_pc_out = m_pc_out | d[12:0];
      8'h24: m_pc_out = m_pc_out & ~d[12:0];
      8'h28: m_sel = m_sel | d[12:0];
      8'h2C: m_sel = m_sel & ~d[12:0];
      8'h44: m_pa_out = m_pa_out | d[7:0];
      8'h48: m_pa_out = m_pa_out & ~d[7:0];
      8'h50: m_pa_dir = m_pa_dir | d[7:0];
      8'h54: m_pa_dir = m_pa_dir & ~d[7:0];
      8'h64: m_pb_out = m_pb_out | d[23:0];
      8'h68: m_pb_out = m_pb_out & ~d[23:0];
      8'h70: m_pb_dir = m_pb_dir | d[23:0];
      8'h74: m_pb_dir = m_pb_dir & ~d[23:0];
      default: ;
    endcase
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
    model_wr(a, d);
  endtask

  task automatic rd_check(input string req, input logic [7:0] a);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, $sformatf("read %h", a), bus_rdata, exp_rd(a));
  endtask

  task automatic pins_check(input string req);
    #1;
    check(req, "pa_out", {24'h0, pa_out}, {24'h0, m_pa_out});
    check(req, "pa_oe",  {24'h0, pa_oe},  {24'h0, m_pa_dir});
    check(req, "pb_out", {8'h0, pb_out},  {8'h0, m_pb_out});
    check(req, "pb_oe",  {8'h0, pb_oe},   {8'h0, m_pb_dir});
    check(req, "pc_out", {19'h0, pc_out}, {19'h0, m_pc_out});
    check(req, "pc_oe",  {19'h0, pc_oe},  {19'h0, m_pc_dir[12:0]});
    check(req, "pd_out", {26'h0, pd_out}, {26'h0, m_hi_out[30:25]});
    check(req, "pd_oe",  {26'h0, pd_oe},  {26'h0, m_pc_dir[30:25]});
    check(req, "gpo_pad", {8'h0, gpo_pad}, {8'h0, m_hi_out[23:0]});
    check(req, "fn_sel", {19'h0, fn_sel}, {19'h0, m_sel});
  endtask

  task automatic all_reads(input string req);
    logic [7:0] st [11] = '{8'h00, 8'h0C, 8'h18, 8'h1C, 8'h30, 8'h40,
                            8'h4C, 8'h58, 8'h60, 8'h6C, 8'h78};
    for (int i = 0; i < 11; i++) rd_check(req, st[i]);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] addr_pool [30] = '{8'h04, 8'h08, 8'h10, 8'h14, 8'h20, 8'h24, 8'h28, 8'h2C,
                                   8'h44, 8'h48, 8'h50, 8'h54, 8'h64, 8'h68, 8'h70, 8'h74,
                                   8'h00, 8'h0C, 8'h18, 8'h1C, 8'h30, 8'h4C, 8'h58, 8'h6C,
                                   8'h78, 8'h34, 8'h80, 8'h41, 8'hFC, 8'h3C};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1 reset state
    pins_check("R1");
    all_reads("R1");

    // R2, R3 set/clear only touch written ones
    wr(8'h44, 32'h0000_00A5);
    wr(8'h44, 32'h0000_000F);
    pins_check("R2");
    check("R2", "pa_out literal", {24'h0, pa_out}, 32'hAF);
    wr(8'h48, 32'h0000_0081);
    pins_check("R3");
    check("R3", "pa_out literal", {24'h0, pa_out}, 32'h2E);

    // R4, R12 direction and upper bits ignored
    wr(8'h70, 32'hFFFF_FFFF);
    pins_check("R4");
    rd_check("R12", 8'h78);
    check("R12", "pb_dir literal", bus_rdata, 32'h00FF_FFFF);
    wr(8'h74, 32'h0000_F00F);
    pins_check("R4");
    wr(8'h10, 32'hFFFF_FFFF);
    rd_check("R5", 8'h18);
    check("R5", "pc_dir literal", bus_rdata, 32'h7E00_1FFF);
    wr(8'h14, 32'h0000_1FFF);
    pins_check("R5");
    check("R5", "pd_oe after port C clear", {26'h0, pd_oe}, 32'h3F);

    // R5 shared high word
    wr(8'h04, 32'hFFFF_FFFF);
    rd_check("R5", 8'h0C);
    check("R5", "hi out literal", bus_rdata, 32'h7EFF_FFFF);
    wr(8'h08, 32'h0500_0003);
    pins_check("R5");
    check("R5", "pd_out literal", {26'h0, pd_out}, 32'h3D);

    // R6 input word layout
    pd_in = 6'h20; gpi_pad = '0; settle();
    rd_check("R6", 8'h00);
    check("R6", "pin5 at 24", bus_rdata, 32'h0100_0000);
    pd_in = 6'h1F; settle();
    rd_check("R6", 8'h00);
    check("R6", "pins0-4 at 10-14", bus_rdata, 32'h0000_7C00);
    pd_in = 6'h00; gpi_pad = '1; settle();
    rd_check("R6", 8'h00);
    check("R6", "input-only fill", bus_rdata, 32'h0EFF_83FF);
    gpi_pad = '0; settle();

    // R7 two-edge input delay
    @(negedge clk);
    pa_in = 8'h5A; bus_addr = 8'h40;
    @(negedge clk); #1;
    check("R7", "after one edge", bus_rdata, 32'h0);
    @(negedge clk); #1;
    check("R7", "after two edges", bus_rdata, 32'h5A);

    // R8 latched output readback differs from pad
    wr(8'h54, 32'hFF);
    wr(8'h44, 32'hFF);
    pa_in = 8'h00; settle();
    rd_check("R8", 8'h4C);
    check("R8", "out state literal", bus_rdata, 32'hFF);
    rd_check("R8", 8'h40);

    // R9 set/clear/unmapped read zero
    rd_check("R9", 8'h44);
    rd_check("R9", 8'h04);
    rd_check("R9", 8'h42);
    rd_check("R9", 8'hF0);

    // R10 writes to state and unmapped ignored
    wr(8'h4C, 32'h0);
    wr(8'h58, 32'hFFFF_FFFF);
    wr(8'h34, 32'hFFFF_FFFF);
    wr(8'h0C, 32'h0);
    wr(8'h45, 32'h0);
    pins_check("R10");
    all_reads("R10");

    // R11 select word
    wr(8'h28, 32'hFFFF_FFFF);
    rd_check("R11", 8'h30);
    check("R11", "sel literal", bus_rdata, 32'h1FFF);
    wr(8'h2C, 32'h0000_1555);
    pins_check("R11");

    // Random mix
    for (int it = 0; it < 400; it++) begin
      if ($urandom_range(0, 5) == 0) begin
        pa_in = 8'($urandom); pb_in = 24'($urandom); pc_in = 13'($urandom);
        pd_in = 6'($urandom); gpi_pad = 22'($urandom);
        settle();
        all_reads("R6");
      end else begin
        logic [7:0] a;
        logic [31:0] d;
        a = addr_pool[$urandom_range(0, 29)];
        d = ($urandom_range(0, 1) == 0) ? $urandom : (32'h1 << $urandom_range(0, 31));
        wr(a, d);
        pins_check("R2");
        rd_check("R10", a);
        rd_check("R9", addr_pool[$urandom_range(0, 15)]);
      end
    end
    all_reads("R12");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule